// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block turns read, write and burst-stop commands for a two-bank, 16-bit synchronous DRAM into a stream of per-beat column addresses. A small mode register holds three settings: the burst length (1, 2, 4 or 8 beats, or a whole 256-column page), the beat ordering (sequential or interleaved) and the read latency (1 to 3 clocks). Each accepted command starts a burst at its own column. The block then steps through the column sequence one beat per clock until the burst is complete, until a stop command arrives, or until a new read or write replaces it.

Read beats pass through a latency pipeline. This produces a read-data-valid strobe, with the matching column, at the programmed distance from the command. Write beats carry per-byte write enables, derived from the upper and lower mask inputs sampled on the same edge. Row opening, precharge, refresh and analogue timing belong to the surrounding controller.

Top module: `sdr_burst_seq`

## Requirements
- R1: After reset, beat_valid, rd_valid and wr_byte_en are all low, and the mode is length 1, sequential, latency 1.
- R2: mode_load writes the mode register. The length code 0/1/2/3 selects 1/2/4/8 beats and code 7 selects a full page. mode_ilv=1 selects interleaved order. mode_lat 1..3 is the read latency. A load takes effect only when no burst is running, no beat or read is in flight, and cmd is NOP. Otherwise it is ignored.
- R3: An illegal load leaves the previous mode unchanged. The illegal loads are: full page with interleaved order, length codes 4 to 6, and latency 0.
- R4: cmd encoding is 0 NOP, 1 read, 2 write, 3 stop. A read or write sampled at edge k presents beat n (n from 0) after edge k+n, with beat_valid high, beat_write set for writes, and beat_bank equal to the command's bank.
- R5: In sequential order with length L, beat n has the start column's upper bits unchanged, and its low log2(L) bits equal (start + n) mod L.
- R6: In interleaved order, beat n's column is the start column XOR n.
- R7: A full-page burst yields column (start + n) mod 256 on every clock, with no end, until a stop command or a new command arrives.
- R8: With length 1, exactly one beat is issued, and beat_valid is low on the following cycle unless a new command arrives.
- R9: A stop command sampled at an edge suppresses every beat from that edge onward. Read beats issued before it still come out at their latency.
- R10: A read or write on any cycle of a running burst abandons the old burst at once. Beat 0 of the new burst follows that edge.
- R11: A read beat presented after edge e raises rd_valid, with rd_col equal to its column, after edge e+lat-1. This is lat clocks after the command for beat 0. Write beats never raise rd_valid.
- R12: For a write beat, wr_byte_en[1] is the inverse of dqm_hi and wr_byte_en[0] is the inverse of dqm_lo, both sampled on the edge that issues the beat. For any other beat both enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_load | input | 1 | Mode register write request |
| mode_len | input | 3 | Burst length code |
| mode_ilv | input | 1 | 1 = interleaved order |
| mode_lat | input | 2 | Read latency in clocks |
| cmd | input | 2 | Command: 0 NOP, 1 read, 2 write, 3 stop |
| cmd_bank | input | 1 | Bank of the command |
| cmd_col | input | 8 | Starting column of the command |
| dqm_hi | input | 1 | Upper byte mask |
| dqm_lo | input | 1 | Lower byte mask |
| beat_valid | output | 1 | A beat is presented this cycle |
| beat_write | output | 1 | Presented beat belongs to a write |
| beat_bank | output | 1 | Bank of the presented beat |
| beat_col | output | 8 | Column of the presented beat |
| wr_byte_en | output | 2 | Per-byte write enables of the beat |
| rd_valid | output | 1 | Read data valid, latency-aligned |
| rd_col | output | 8 | Column of the read data now valid |

## Verification
Inputs are driven at the falling edge and outputs are sampled at the following falling edge. A command applied before edge k is therefore checked at the sample that follows edge k (beat 0), and beat n is checked n samples later. The bench predicts the beat stream, including any stop or replacement, as a table indexed by sample. rd_valid and rd_col are then checked against the entry lat-1 samples earlier, and each write enable is checked against the mask pattern driven just before the edge that issued the beat. Mode loads are followed by idle cycles, so every burst is measured only after the pipeline has drained.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

    typedef enum logic [1:0] {
        CMD_NOP  = 2'd0,
        CMD_RD   = 2'd1,
        CMD_WR   = 2'd2,
        CMD_STOP = 2'd3
    } cmd_e;

    localparam logic [2:0] LEN_PAGE = 3'd7;

    typedef struct packed {
        logic [2:0] len_code;
        logic       ilv;
        logic [1:0] lat;
    } mode_t;

endpackage

// File: rtl/sdr_mode_reg.sv
module sdr_mode_reg
    import sdr_seq_pkg::*;
#(
    parameter int MAX_LAT = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       idle,
    input  logic [2:0] len_code,
    input  logic       ilv,
    input  logic [1:0] lat,
    output mode_t      mode_q
);

    mode_t mode_d;
    logic  legal;

    always_comb begin
        legal = ((len_code <= 3'd3) || (len_code == LEN_PAGE))
              && !(ilv && (len_code == LEN_PAGE))
              && (int'(lat) >= 1) && (int'(lat) <= MAX_LAT);
        mode_d = mode_q;
        if (load && idle && legal) begin
            mode_d.len_code = len_code;
            mode_d.ilv      = ilv;
            mode_d.lat      = lat;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '{len_code: 3'd0, ilv: 1'b0, lat: 2'd1};
        end else begin
            mode_q <= mode_d;
        end
    end

    AST_MODE_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> $stable(mode_q)); // R2
    AST_NO_ILV_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mode_q.ilv && (mode_q.len_code == LEN_PAGE))); // R3

endmodule

// File: rtl/sdr_col_gen.sv
module sdr_col_gen #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] start,
    input  logic [COL_W-1:0] idx,
    input  logic [2:0]       len_code,
    input  logic             ilv,
    output logic [COL_W-1:0] col,
    output logic [COL_W-1:0] wrap_mask
);

    always_comb begin
        case (len_code)
            3'd0:    wrap_mask = '0;
            3'd1:    wrap_mask = COL_W'(1);
            3'd2:    wrap_mask = COL_W'(3);
            3'd3:    wrap_mask = COL_W'(7);
            default: wrap_mask = '1;
        endcase
        if (ilv) begin
            col = start ^ (idx & wrap_mask);
        end else begin
            col = (start & ~wrap_mask) | ((start + idx) & wrap_mask);
        end
    end

endmodule

// File: rtl/sdr_burst_ctr.sv
module sdr_burst_ctr
    import sdr_seq_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cmd_e             cmd,
    input  logic             cmd_bank,
    input  logic [COL_W-1:0] cmd_col,
    input  logic [1:0]       dqm,
    input  mode_t            mode,
    output logic             beat_vld,
    output logic             beat_wr,
    output logic             beat_bank,
    output logic [COL_W-1:0] beat_col,
    output logic [1:0]       wr_be,
    output logic             idle
);

    typedef struct packed {
        logic             active;
        logic             bank;
        logic             wr;
        logic [COL_W-1:0] start;
        logic [COL_W-1:0] idx;
        logic [2:0]       len_code;
        logic             ilv;
        logic             beat_vld;
        logic             beat_wr;
        logic             beat_bank;
        logic [COL_W-1:0] beat_col;
        logic [1:0]       be;
    } st_t;

    st_t              st_d, st_q;
    logic             new_cmd;
    logic [COL_W-1:0] g_start, g_idx, g_col, g_mask;
    logic [2:0]       g_len;
    logic             g_ilv;

    always_comb begin
        new_cmd = (cmd == CMD_RD) || (cmd == CMD_WR);
        g_start = new_cmd ? cmd_col       : st_q.start;
        g_idx   = new_cmd ? '0            : st_q.idx;
        g_len   = new_cmd ? mode.len_code : st_q.len_code;
        g_ilv   = new_cmd ? mode.ilv      : st_q.ilv;
    end

    sdr_col_gen #(.COL_W(COL_W)) u_col_gen (
        .start     (g_start),
        .idx       (g_idx),
        .len_code  (g_len),
        .ilv       (g_ilv),
        .col       (g_col),
        .wrap_mask (g_mask)
    );

    always_comb begin
        st_d          = st_q;
        st_d.beat_vld = 1'b0;
        st_d.be       = 2'b00;
        if (new_cmd) begin
            st_d.active    = (mode.len_code != 3'd0);
            st_d.bank      = cmd_bank;
            st_d.wr        = (cmd == CMD_WR);
            st_d.start     = cmd_col;
            st_d.idx       = COL_W'(1);
            st_d.len_code  = mode.len_code;
            st_d.ilv       = mode.ilv;
            st_d.beat_vld  = 1'b1;
            st_d.beat_wr   = (cmd == CMD_WR);
            st_d.beat_bank = cmd_bank;
            st_d.beat_col  = g_col;
            st_d.be        = (cmd == CMD_WR) ? ~dqm : 2'b00;
        end else if (cmd == CMD_STOP) begin
            st_d.active = 1'b0;
        end else if (st_q.active) begin
            st_d.beat_vld  = 1'b1;
            st_d.beat_wr   = st_q.wr;
            st_d.beat_bank = st_q.bank;
            st_d.beat_col  = g_col;
            st_d.be        = st_q.wr ? ~dqm : 2'b00;
            st_d.idx       = st_q.idx + COL_W'(1);
            st_d.active    = (st_q.len_code == LEN_PAGE) || (st_q.idx != g_mask);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign beat_vld  = st_q.beat_vld;
    assign beat_wr   = st_q.beat_wr;
    assign beat_bank = st_q.beat_bank;
    assign beat_col  = st_q.beat_col;
    assign wr_be     = st_q.be;
    assign idle      = !st_q.active && !st_q.beat_vld;

    AST_STOP_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_STOP) |=> !beat_vld); // R9
    AST_LEN1_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (new_cmd && (mode.len_code == 3'd0)) |=> !st_q.active); // R8
    AST_CMD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        new_cmd |=> (beat_vld && (beat_col == $past(cmd_col)))); // R10

endmodule

// File: rtl/sdr_rd_pipe.sv
module sdr_rd_pipe #(
    parameter int COL_W   = 8,
    parameter int MAX_LAT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_in,
    input  logic [COL_W-1:0] col_in,
    input  logic [1:0]       lat,
    output logic             rd_valid,
    output logic [COL_W-1:0] rd_col,
    output logic             empty
);

    typedef struct packed {
        logic [MAX_LAT-1:1]            vld;
        logic [MAX_LAT-1:1][COL_W-1:0] col;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d        = pipe_q;
        pipe_d.vld[1] = rd_in;
        pipe_d.col[1] = col_in;
        for (int i = 2; i < MAX_LAT; i++) begin
            pipe_d.vld[i] = pipe_q.vld[i-1];
            pipe_d.col[i] = pipe_q.col[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    always_comb begin
        rd_valid = rd_in;
        rd_col   = col_in;
        for (int i = 1; i < MAX_LAT; i++) begin
            if (int'(lat) == i + 1) begin
                rd_valid = pipe_q.vld[i];
                rd_col   = pipe_q.col[i];
            end
        end
        empty = (pipe_q.vld == '0);
    end

    AST_RD_LAT2: assert property (@(posedge clk) disable iff (!rst_n)
        (lat == 2'd2) |-> (rd_valid == $past(rd_in))); // R11

endmodule

// File: rtl/sdr_burst_seq.sv
module sdr_burst_seq
    import sdr_seq_pkg::*;
#(
    parameter int COL_W   = 8,
    parameter int MAX_LAT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_load,
    input  logic [2:0]       mode_len,
    input  logic             mode_ilv,
    input  logic [1:0]       mode_lat,
    input  logic [1:0]       cmd,
    input  logic             cmd_bank,
    input  logic [COL_W-1:0] cmd_col,
    input  logic             dqm_hi,
    input  logic             dqm_lo,
    output logic             beat_valid,
    output logic             beat_write,
    output logic             beat_bank,
    output logic [COL_W-1:0] beat_col,
    output logic [1:0]       wr_byte_en,
    output logic             rd_valid,
    output logic [COL_W-1:0] rd_col
);

    cmd_e  cmd_w;
    mode_t mode;
    logic  ctr_idle, pipe_empty, seq_idle;

    assign cmd_w    = cmd_e'(cmd);
    assign seq_idle = ctr_idle && pipe_empty && (cmd_w == CMD_NOP);

    sdr_mode_reg #(.MAX_LAT(MAX_LAT)) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (mode_load),
        .idle     (seq_idle),
        .len_code (mode_len),
        .ilv      (mode_ilv),
        .lat      (mode_lat),
        .mode_q   (mode)
    );

    sdr_burst_ctr #(.COL_W(COL_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd_w),
        .cmd_bank  (cmd_bank),
        .cmd_col   (cmd_col),
        .dqm       ({dqm_hi, dqm_lo}),
        .mode      (mode),
        .beat_vld  (beat_valid),
        .beat_wr   (beat_write),
        .beat_bank (beat_bank),
        .beat_col  (beat_col),
        .wr_be     (wr_byte_en),
        .idle      (ctr_idle)
    );

    sdr_rd_pipe #(.COL_W(COL_W), .MAX_LAT(MAX_LAT)) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_in    (beat_valid && !beat_write),
        .col_in   (beat_col),
        .lat      (mode.lat),
        .rd_valid (rd_valid),
        .rd_col   (rd_col),
        .empty    (pipe_empty)
    );

    AST_WR_NO_RDV: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_write && (mode.lat == 2'd1)) |-> !rd_valid); // R11

endmodule

// File: tb/test_sdr_burst_seq.sv
module test_sdr_burst_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_load = 1'b0;
    logic [2:0] mode_len = 3'd0;
    logic       mode_ilv = 1'b0;
    logic [1:0] mode_lat = 2'd1;
    logic [1:0] cmd = 2'd0;
    logic       cmd_bank = 1'b0;
    logic [7:0] cmd_col = 8'd0;
    logic       dqm_hi = 1'b0;
    logic       dqm_lo = 1'b0;
    logic       beat_valid, beat_write, beat_bank, rd_valid;
    logic [7:0] beat_col, rd_col;
    logic [1:0] wr_byte_en;

    int  vectors = 0;
    int  fails   = 0;
    bit  done    = 0;

    bit  exp_v [0:399];
    int  exp_c [0:399];
    bit  exp_w [0:399];
    bit  exp_b [0:399];

    always #5 clk = ~clk;

    sdr_burst_seq i_sdr_burst_seq (
        .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_len(mode_len),
        .mode_ilv(mode_ilv), .mode_lat(mode_lat), .cmd(cmd), .cmd_bank(cmd_bank),
        .cmd_col(cmd_col), .dqm_hi(dqm_hi), .dqm_lo(dqm_lo),
        .beat_valid(beat_valid), .beat_write(beat_write), .beat_bank(beat_bank),
        .beat_col(beat_col), .wr_byte_en(wr_byte_en), .rd_valid(rd_valid),
        .rd_col(rd_col)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int exp_col(int s, int n, int len, bit ilv);
        if (ilv) return s ^ n;
        return (s / len) * len + ((s % len) + n) % len;
    endfunction

    task automatic load_mode(input int lc, input bit ilv, input int lat);
        mode_load = 1'b1; mode_len = 3'(lc); mode_ilv = ilv; mode_lat = 2'(lat);
        @(negedge clk);
        mode_load = 1'b0;
        @(negedge clk);
    endtask

    // kind: 1 read, 2 write, 3 stop; stop_at < 0 means no second command
    task automatic run_burst(input string tag, input bit first_wr, input int start,
                             input int len, input bit ilv, input int lat,
                             input int stop_at, input int kind, input int start2,
                             input int nsamp);
        for (int j = 0; j < nsamp; j++) begin
            if (stop_at < 0 || j < stop_at) begin
                exp_v[j] = (len == 256) || (j < len);
                exp_c[j] = exp_col(start, j, len, ilv);
                exp_w[j] = first_wr;
                exp_b[j] = 1'b1;
            end else if (kind == 3) begin
                exp_v[j] = 1'b0; exp_c[j] = 0; exp_w[j] = 1'b0; exp_b[j] = 1'b0;
            end else begin
                exp_v[j] = (len == 256) || (j - stop_at < len);
                exp_c[j] = exp_col(start2, j - stop_at, len, ilv);
                exp_w[j] = (kind == 2);
                exp_b[j] = 1'b0;
            end
        end
        for (int j = 0; j < nsamp; j++) begin
            if (j == 0) begin
                cmd = first_wr ? 2'd2 : 2'd1; cmd_col = 8'(start); cmd_bank = 1'b1;
            end else if (j == stop_at) begin
                cmd = 2'(kind); cmd_col = 8'(start2); cmd_bank = 1'b0;
            end else begin
                cmd = 2'd0;
            end
            dqm_lo = (j % 2) == 1;
            dqm_hi = ((j / 2) % 2) == 1;
            @(negedge clk);
            chk(tag, "beat_valid", int'(beat_valid), int'(exp_v[j]));
            if (exp_v[j]) begin
                chk(tag, "beat_col", int'(beat_col), exp_c[j]);
                chk("R4", "beat_write", int'(beat_write), int'(exp_w[j]));
                chk("R4", "beat_bank", int'(beat_bank), int'(exp_b[j]));
            end
            chk("R12", "wr_byte_en", int'(wr_byte_en),
                (exp_v[j] && exp_w[j]) ? (3 - (j % 4)) : 0);
            begin
                int src = j - (lat - 1);
                bit rv = (src >= 0) && exp_v[src] && !exp_w[src];
                chk("R11", "rd_valid", int'(rd_valid), int'(rv));
                if (rv) chk("R11", "rd_col", int'(rd_col), exp_c[src]);
            end
        end
        cmd = 2'd0; dqm_lo = 1'b0; dqm_hi = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        int starts [7] = '{0, 3, 5, 6, 13, 250, 255};
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "beat_valid", int'(beat_valid), 0);
        chk("R1", "rd_valid", int'(rd_valid), 0);
        chk("R1", "wr_byte_en", int'(wr_byte_en), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "beat_valid idle", int'(beat_valid), 0);
        // R1: default mode is length 1, sequential, latency 1
        run_burst("R1", 1'b0, 37, 1, 1'b0, 1, -1, 0, 0, 5);
        run_burst("R4", 1'b1, 200, 1, 1'b0, 1, -1, 0, 0, 5);

        // R5 / R6 sweep over lengths, latencies, orders and starts
        for (int ilv = 0; ilv < 2; ilv++)
            for (int lc = 0; lc < 4; lc++)
                for (int lat = 1; lat <= 3; lat++)
                    for (int s = 0; s < 7; s++) begin
                        load_mode(lc, ilv[0], lat);
                        run_burst(ilv ? "R6" : "R5", 1'b0, starts[s], 1 << lc, ilv[0],
                                  lat, -1, 0, 0, (1 << lc) + lat + 2);
                        run_burst(ilv ? "R6" : "R5", 1'b1, starts[s], 1 << lc, ilv[0],
                                  lat, -1, 0, 0, (1 << lc) + lat + 2);
                    end

        // R8: single-beat bursts
        load_mode(0, 1'b0, 2);
        run_burst("R8", 1'b0, 77, 1, 1'b0, 2, -1, 0, 0, 6);
        run_burst("R8", 1'b1, 78, 1, 1'b0, 2, -1, 0, 0, 6);

        // R7: full page sequential runs past the wrap, then stops
        load_mode(7, 1'b0, 3);
        run_burst("R7", 1'b0, 250, 256, 1'b0, 3, 290, 3, 0, 300);
        run_burst("R7", 1'b1, 9, 256, 1'b0, 3, 20, 1, 128, 30);
        // stop the replacement page burst
        cmd = 2'd3;
        @(negedge clk);
        cmd = 2'd0;
        @(negedge clk);
        chk("R9", "beat_valid after stop", int'(beat_valid), 0);
        repeat (4) @(negedge clk);

        // R9: stop mid-burst, read beats already issued still emerge
        load_mode(3, 1'b0, 3);
        run_burst("R9", 1'b0, 12, 8, 1'b0, 3, 3, 3, 0, 14);
        run_burst("R9", 1'b1, 12, 8, 1'b0, 3, 5, 3, 0, 14);
        load_mode(2, 1'b1, 1);
        run_burst("R9", 1'b0, 6, 4, 1'b1, 1, 1, 3, 0, 8);

        // R10: replacement on various cycles
        load_mode(3, 1'b0, 2);
        run_burst("R10", 1'b0, 3, 8, 1'b0, 2, 2, 2, 17, 16);
        run_burst("R10", 1'b0, 3, 8, 1'b0, 2, 1, 1, 40, 16);
        run_burst("R10", 1'b1, 61, 8, 1'b0, 2, 7, 1, 250, 20);
        load_mode(3, 1'b1, 3);
        run_burst("R10", 1'b1, 21, 8, 1'b1, 3, 4, 1, 99, 18);

        // R2: load while a burst is running is ignored
        load_mode(3, 1'b0, 1);
        cmd = 2'd1; cmd_col = 8'd0;
        @(negedge clk);
        cmd = 2'd0; mode_load = 1'b1; mode_len = 3'd0; mode_ilv = 1'b0; mode_lat = 2'd3;
        @(negedge clk);
        mode_load = 1'b0;
        repeat (12) @(negedge clk);
        run_burst("R2", 1'b0, 44, 8, 1'b0, 1, -1, 0, 0, 12);

        // R3: illegal loads keep the previous mode (length 8, seq, lat 1)
        load_mode(7, 1'b1, 2);
        run_burst("R3", 1'b0, 45, 8, 1'b0, 1, -1, 0, 0, 12);
        load_mode(5, 1'b0, 2);
        run_burst("R3", 1'b0, 46, 8, 1'b0, 1, -1, 0, 0, 12);
        load_mode(1, 1'b0, 0);
        run_burst("R3", 1'b1, 47, 8, 1'b0, 1, -1, 0, 0, 12);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule